// File: doc/BRIEF.md
# Branch Condition and Target Resolver

This combinational unit sits beside the decode stage of a core that executes a 16-bit compressed instruction set. Each cycle it looks at one instruction halfword, the address of that halfword, the current link-register contents and the four arithmetic flags (negative, zero, carry, overflow). From these it decides whether control flow leaves the sequential path and what the next fetch address is.

It resolves four kinds of encoding:

- conditional branches, including the full sixteen-entry condition table;
- unconditional short branches;
- the two halves of a long branch-with-link, which pass the upper part of the offset from one halfword to the next through the link register;
- software interrupts.

It also flags encodings that fall inside its opcode space but have no meaning. Flag generation and pipeline flushing belong to neighbouring logic. The address width is a parameter.

Top module: `branch_resolve`

## Requirements
- R1: For a halfword `1101 cccc iiiiiiii`, the branch is taken as follows. Condition 0000 is taken when Z=1 and 0001 when Z=0. Condition 0010 is taken when C=1 and 0011 when C=0. Condition 0100 is taken when N=1 and 0101 when N=0. Condition 0110 is taken when V=1 and 0111 when V=0.
- R2: For the same halfword, the remaining conditions are taken as follows. Condition 1000 is taken when C=1 and Z=0. Condition 1001 is taken when C=0 or Z=1. Condition 1010 is taken when N equals V, and 1011 when N differs from V. Condition 1100 is taken when Z=0 and N equals V. Condition 1101 is taken when Z=1 or N differs from V.
- R3: A taken conditional branch sets `next_pc` to pc + 4 + (the 8-bit field in bits 7:0, sign-extended and doubled).
- R4: When no branch is taken (a false condition, or a halfword that is not a branch), `taken` is 0 and `next_pc` is pc + 2. In that case `lr_we` is 0 unless R8 applies.
- R5: A halfword `11100 oooooooooo o` (bits 15:11 = 11100) is always taken. Its `next_pc` is pc + 4 + (the 11-bit field in bits 10:0, sign-extended and doubled).
- R6: Condition 1110 in the conditional format and any halfword with bits 15:11 = 11101 raise `undef`. When `undef` is high, `taken` and `lr_we` are 0 and `next_pc` is pc + 2.
- R7: Condition 1111 in the conditional format raises `swi_valid` with `swi_num` equal to bits 7:0. `taken` stays 0 and `next_pc` is pc + 2. When `swi_valid` is 0, `swi_num` reads 0.
- R8: A halfword with bits 15:11 = 11110 (first half of a long branch-with-link) sets `lr_we`. It writes `lr_wdata` = pc + 4 + (bits 10:0 sign-extended and shifted left by 12). `taken` stays 0 and `next_pc` is pc + 2.
- R9: A halfword with bits 15:11 = 11111 (second half) is taken with `next_pc` = lr_in + (bits 10:0 doubled). It also sets `lr_we` with `lr_wdata` = (pc + 2) with bit 0 forced to 1.
- R10: At most one of `taken`, `swi_valid` and `undef` is high for any input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 16 | Instruction halfword being resolved |
| pc | input | AW | Address of that halfword |
| lr_in | input | AW | Current link-register value |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| taken | output | 1 | Control flow leaves the sequential path |
| next_pc | output | AW | Address of the next fetch |
| lr_we | output | 1 | Link-register write enable |
| lr_wdata | output | AW | Value for the link register |
| swi_valid | output | 1 | Software interrupt requested |
| swi_num | output | 8 | Software interrupt number |
| undef | output | 1 | Claimed but undefined encoding |

## Verification
The bench builds the unit with AW = 32, which is the width the long branch-with-link needs. At that width the 22-bit combined offset fits with its sign. Negative offsets also wrap the full address space, so backward branches near address zero and forward branches near the top of memory can both be checked against modular arithmetic. The condition table is swept over all sixteen flag combinations. The long branch is exercised as a real pair: the first half's `lr_wdata` is fed back as the second half's `lr_in`.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int AW = 32
) (
  input  logic [15:0]   instr,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] lr_in,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_v,
  output logic          taken,
  output logic [AW-1:0] next_pc,
  output logic          lr_we,
  output logic [AW-1:0] lr_wdata,
  output logic          swi_valid,
  output logic [7:0]    swi_num,
  output logic          undef
);

  localparam int PAD8  = AW - 9;
  localparam int PAD11 = AW - 12;
  localparam int PADHI = AW - 23;

  logic [3:0]    cond;
  logic          is_bcc, is_jmp, is_gap, is_lhi, is_llo;
  logic          cond_true, cond_bad, cond_swi;
  logic [AW-1:0] pc_seq, pc_rel, off8, off11, off_hi, off_lo;

  assign cond   = instr[11:8];
  assign is_bcc = instr[15:12] == 4'b1101;
  assign is_jmp = instr[15:11] == 5'b11100;
  assign is_gap = instr[15:11] == 5'b11101;
  assign is_lhi = instr[15:11] == 5'b11110;
  assign is_llo = instr[15:11] == 5'b11111;

  assign pc_seq = pc + AW'(2);
  assign pc_rel = pc + AW'(4);

  assign off8   = {{PAD8{instr[7]}}, instr[7:0], 1'b0};
  assign off11  = {{PAD11{instr[10]}}, instr[10:0], 1'b0};
  assign off_hi = {{PADHI{instr[10]}}, instr[10:0], 12'b0};
  assign off_lo = {{(AW-12){1'b0}}, instr[10:0], 1'b0};

  always_comb begin
    cond_bad = 1'b0;
    cond_swi = 1'b0;
    unique case (cond)
      4'b0000: cond_true = flag_z;
      4'b0001: cond_true = !flag_z;
      4'b0010: cond_true = flag_c;
      4'b0011: cond_true = !flag_c;
      4'b0100: cond_true = flag_n;
      4'b0101: cond_true = !flag_n;
      4'b0110: cond_true = flag_v;
      4'b0111: cond_true = !flag_v;
      4'b1000: cond_true = flag_c && !flag_z;
      4'b1001: cond_true = !flag_c || flag_z;
      4'b1010: cond_true = flag_n == flag_v;
      4'b1011: cond_true = flag_n != flag_v;
      4'b1100: cond_true = !flag_z && (flag_n == flag_v);
      4'b1101: cond_true = flag_z || (flag_n != flag_v);
      4'b1110: begin cond_true = 1'b0; cond_bad = 1'b1; end
      default: begin cond_true = 1'b0; cond_swi = 1'b1; end
    endcase
  end

  assign swi_valid = is_bcc && cond_swi;
  assign swi_num   = swi_valid ? instr[7:0] : 8'h00;
  assign undef     = is_gap || (is_bcc && cond_bad);
  assign taken     = (is_bcc && cond_true) || is_jmp || is_llo;

  assign lr_we     = is_lhi || is_llo;
  assign lr_wdata  = is_llo ? (pc_seq | AW'(1)) : (pc_rel + off_hi);

  always_comb begin
    next_pc = pc_seq;
    if (is_bcc && cond_true) next_pc = pc_rel + off8;
    else if (is_jmp)         next_pc = pc_rel + off11;
    else if (is_llo)         next_pc = lr_in + off_lo;
  end

  always_comb begin
    p_one_event_r10: assert ($onehot0({taken, swi_valid, undef}))
      else $error("more than one event raised");
    p_undef_quiet_r6: assert (!undef || (!taken && !lr_we && next_pc == pc + AW'(2)))
      else $error("undefined encoding not quiet");
    p_swi_seq_r7: assert (!swi_valid || (!lr_we && next_pc == pc + AW'(2)))
      else $error("interrupt left sequential path");
    p_swi_zero_r7: assert (swi_valid || swi_num == 8'h00)
      else $error("interrupt number without request");
    p_link_odd_r9: assert (!(lr_we && taken) || lr_wdata[0])
      else $error("return link lacks bit 0");
    p_seq_r4: assert (taken || next_pc == pc + AW'(2))
      else $error("fallthrough address wrong");
  end

endmodule

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] instr;
  logic [31:0] pc, lr_in;
  logic        fn, fz, fc, fv;
  logic        taken, lr_we, swi_valid, undef;
  logic [31:0] next_pc, lr_wdata;
  logic [7:0]  swi_num;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  branch_resolve #(.AW(32)) uut (
    .instr(instr), .pc(pc), .lr_in(lr_in),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .taken(taken), .next_pc(next_pc), .lr_we(lr_we), .lr_wdata(lr_wdata),
    .swi_valid(swi_valid), .swi_num(swi_num), .undef(undef)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] i, input logic [31:0] p, input logic [31:0] l,
                       input logic [3:0] nzcv);
    @(posedge clk);
    instr = i; pc = p; lr_in = l;
    {fn, fz, fc, fv} = nzcv;
    @(negedge clk);
  endtask

  function automatic bit want(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy & !z;
      4'd9:  return !cy | z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z & (n == v);
      4'd13: return z | (n != v);
      default: return 0;
    endcase
  endfunction

  task automatic t_idle;
    drive(16'h0000, 32'h0000_0100, 32'h0, 4'h0);
    chk("R4 idle taken", {31'b0, taken}, 32'd0);
    chk("R4 idle next", next_pc, 32'h0000_0102);
    chk("R4 idle lr_we", {31'b0, lr_we}, 32'd0);
    chk("R10 idle events", {29'b0, taken, swi_valid, undef}, 32'd0);
  endtask

  task automatic t_cond_simple;
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++) begin
        bit w = want(4'(c), 4'(f));
        drive({4'hD, 4'(c), 8'h10}, 32'h0000_2000, 32'h0, 4'(f));
        chk("R1 taken", {31'b0, taken}, {31'b0, w});
        chk("R1 next", next_pc, w ? 32'h0000_2024 : 32'h0000_2002);
      end
  endtask

  task automatic t_cond_signed;
    for (int c = 8; c < 14; c++)
      for (int f = 0; f < 16; f++) begin
        bit w = want(4'(c), 4'(f));
        drive({4'hD, 4'(c), 8'hF0}, 32'h0000_3000, 32'h0, 4'(f));
        chk("R2 taken", {31'b0, taken}, {31'b0, w});
        chk("R2 next", next_pc, w ? 32'h0000_2FE4 : 32'h0000_3002);
        chk("R4 lr_we", {31'b0, lr_we}, 32'd0);
      end
  endtask

  task automatic t_offsets;
    drive(16'hD07F, 32'h0000_1000, 32'h0, 4'b0100);
    chk("R3 max fwd", next_pc, 32'h0000_1000 + 32'd4 + 32'd254);
    drive(16'hD080, 32'h0000_1000, 32'h0, 4'b0100);
    chk("R3 max back", next_pc, 32'h0000_1000 + 32'd4 - 32'd256);
    drive(16'hD0FE, 32'h0000_0000, 32'h0, 4'b0100);
    chk("R3 wrap", next_pc, 32'h0000_0000);
    drive(16'hD0FD, 32'h0000_0000, 32'h0, 4'b0100);
    chk("R3 wrap neg", next_pc, 32'hFFFF_FFFE);
  endtask

  task automatic t_jump;
    drive(16'hE3FF, 32'h0000_4000, 32'h0, 4'h0);
    chk("R5 taken", {31'b0, taken}, 32'd1);
    chk("R5 fwd", next_pc, 32'h0000_4000 + 32'd4 + 32'd2046);
    drive(16'hE400, 32'h0000_4000, 32'h0, 4'hF);
    chk("R5 back", next_pc, 32'h0000_4000 + 32'd4 - 32'd2048);
    chk("R5 no link", {31'b0, lr_we}, 32'd0);
  endtask

  task automatic t_undef;
    drive(16'hDE55, 32'h0000_5000, 32'h0, 4'hF);
    chk("R6 cond undef", {31'b0, undef}, 32'd1);
    chk("R6 cond taken", {31'b0, taken}, 32'd0);
    chk("R6 cond next", next_pc, 32'h0000_5002);
    drive(16'hE800, 32'h0000_5000, 32'h0, 4'h0);
    chk("R6 gap undef", {31'b0, undef}, 32'd1);
    chk("R6 gap quiet", {30'b0, taken, lr_we}, 32'd0);
    chk("R6 gap next", next_pc, 32'h0000_5002);
    drive(16'hD555, 32'h0000_5000, 32'h0, 4'h0);
    chk("R6 no undef", {31'b0, undef}, 32'd0);
  endtask

  task automatic t_swi;
    drive(16'hDFA5, 32'h0000_6000, 32'h0, 4'h0);
    chk("R7 valid", {31'b0, swi_valid}, 32'd1);
    chk("R7 num", {24'b0, swi_num}, 32'h0000_00A5);
    chk("R7 taken", {31'b0, taken}, 32'd0);
    chk("R7 next", next_pc, 32'h0000_6002);
    drive(16'hD0A5, 32'h0000_6000, 32'h0, 4'h0);
    chk("R7 idle num", {23'b0, swi_valid, swi_num}, 32'd0);
  endtask

  task automatic t_long(input logic [21:0] off, input logic [31:0] p);
    logic [31:0] link;
    logic [31:0] exp_lr = p + 32'd4 + {{10{off[21]}}, off};
    exp_lr[11:0] = 12'h000;
    exp_lr = p + 32'd4 + {{10{off[21]}}, off[21:11], 11'b0} * 32'd2;
    drive({5'b11110, off[21:11]}, p, 32'hDEAD_BEEF, 4'h0);
    chk("R8 lr_we", {31'b0, lr_we}, 32'd1);
    chk("R8 lr value", lr_wdata, exp_lr);
    chk("R8 not taken", {31'b0, taken}, 32'd0);
    chk("R8 next", next_pc, p + 32'd2);
    link = lr_wdata;
    drive({5'b11111, off[10:0]}, p + 32'd2, link, 4'h0);
    chk("R9 taken", {31'b0, taken}, 32'd1);
    chk("R9 target", next_pc, p + 32'd4 + {{9{off[21]}}, off, 1'b0});
    chk("R9 lr_we", {31'b0, lr_we}, 32'd1);
    chk("R9 return", lr_wdata, (p + 32'd4) | 32'd1);
  endtask

  task automatic t_other;
    drive(16'hB500, 32'h0000_7000, 32'h0, 4'hF);
    chk("R4 push next", next_pc, 32'h0000_7002);
    chk("R4 push quiet", {28'b0, taken, lr_we, swi_valid, undef}, 32'd0);
    drive(16'h4770, 32'h0000_7000, 32'h0, 4'hF);
    chk("R10 other quiet", {29'b0, taken, swi_valid, undef}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    instr = 16'h0; pc = 32'h0; lr_in = 32'h0; {fn, fz, fc, fv} = 4'h0;
    t_idle();
    t_cond_simple();
    t_cond_signed();
    t_offsets();
    t_jump();
    t_undef();
    t_swi();
    t_long(22'h000123, 32'h0001_0000);
    t_long(22'h3FFF00, 32'h0001_0000);
    t_long(22'h1FFFFF, 32'h0000_0040);
    t_other();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule